// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block merges a group of input pins that share a single external interrupt vector into one interrupt request. Each pin has its own enable bit. The enabled pins pass through a two-flop synchroniser and are then merged by a NAND. The merged line is presented in pin polarity: it is high only while every enabled pin is high. Disabled pins are forced to the inactive level, so they never affect the merged line.

A two-bit sensitivity field selects how the merged line is turned into a request. It can select a low level, a rising edge, a falling edge, or either edge. In the edge modes, a detected edge is held as a pending request until the interrupt controller strobes its acknowledge on entry to the service routine. In the level mode, the request simply follows the merged line. Because the pins are merged before detection, any enabled pin held low blocks rising-edge events from all the other pins. A separate wake output lets the request bring the system out of HALT.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, with all pins high, `irq_o` and `wake_o` are low.
- R2: The merged line is high exactly when every pin whose `pin_en_i` bit is 1 is high. Pins whose enable bit is 0 have no effect, and with no pin enabled the merged line is constantly high.
- R3: With `sense_i` = 2'b01, a low-to-high transition of the merged line latches a request. While any enabled pin stays low, no other pin can produce that event.
- R4: With `sense_i` = 2'b10, a high-to-low transition of the merged line latches a request.
- R5: With `sense_i` = 2'b11, a transition of the merged line in either direction latches a request.
- R6: With `sense_i` = 2'b00, `irq_o` is high exactly while the merged line is low. Nothing is latched, and `ack_i` has no effect.
- R7: In the edge modes, a latched request stays high until `ack_i` is sampled high. It is then clear from the following cycle, unless a new edge arrives in the same cycle.
- R8: Any change of `sense_i` clears a latched request, and the change itself produces no event.
- R9: A pin change driven before clock edge 1 appears on `irq_o` after edge 3 in the edge modes and after edge 2 in the level mode. Before those edges, `irq_o` is unchanged.
- R10: `wake_o` equals `irq_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| pin_en_i | input | NPINS | Per-pin interrupt enable |
| sense_i | input | 2 | Sensitivity: 00 low level, 01 rising, 10 falling, 11 both edges |
| ack_i | input | 1 | Service-entry acknowledge strobe from the controller |
| irq_o | output | 1 | Request to the interrupt controller |
| wake_o | output | 1 | HALT wake-up request |

## Verification
The properties assume `ack_i` is a strobe sampled on the same edge as the pending register. They also treat the cycle in which `sense_i` differs from its previous value as a clearing cycle, not a detecting one. The stimulus changes pins, enables, sensitivity and acknowledge only at falling clock edges. Before each observed transition, it holds a configuration for four cycles and then acknowledges, so synchroniser history and clearing on a mode change never blur the expected value. The sweeps cover every enable mask and every pair of start and end pin patterns in each edge mode, plus every mask and pattern in level mode.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic   pend;
        logic   line_prev;
        sense_e sense;
    } det_state_t;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '1;
        else         stg_q <= stg_d;
    end

    assign q_o = stg_q[LAST];
endmodule

// File: rtl/eid_combine.sv
module eid_combine #(
    parameter int W = 4
) (
    input  logic [W-1:0] pins_i,
    input  logic [W-1:0] en_i,
    output logic         line_o
);
    logic [W-1:0] gated;
    logic         nand_out;

    for (genvar g = 0; g < W; g++) begin : g_gate
        // a disabled pin is forced to the idle (high) level
        assign gated[g] = pins_i[g] | ~en_i[g];
    end

    assign nand_out = ~&gated;
    // back to pin polarity: high only when every enabled pin is high
    assign line_o   = ~nand_out;
endmodule

// File: rtl/eid_detect.sv
module eid_detect
    import eid_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       line_i,
    input  logic [1:0] sense_i,
    input  logic       ack_i,
    output logic       irq_o
);
    det_state_t st_d, st_q;
    sense_e     mode;
    logic       rise, fall, evt, mode_chg;

    always_comb begin
        mode     = sense_e'(sense_i);
        rise     = line_i & ~st_q.line_prev;
        fall     = ~line_i & st_q.line_prev;
        mode_chg = (mode != st_q.sense);
        unique case (mode)
            SENSE_RISE: evt = rise;
            SENSE_FALL: evt = fall;
            SENSE_BOTH: evt = rise | fall;
            default:    evt = 1'b0;
        endcase

        st_d           = st_q;
        st_d.line_prev = line_i;
        st_d.sense     = mode;
        if (mode_chg || mode == SENSE_LOW) st_d.pend = 1'b0;
        else if (evt)                      st_d.pend = 1'b1;
        else if (ack_i)                    st_d.pend = 1'b0;

        irq_o = (mode == SENSE_LOW) ? ~line_i : st_q.pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pend      <= 1'b0;
            st_q.line_prev <= 1'b1;
            st_q.sense     <= SENSE_LOW;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] pin_en_i,
    input  logic [1:0]       sense_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             wake_o
);
    logic [NPINS-1:0] pin_sync;
    logic             line_w;
    logic             irq_w;

    eid_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (pin_sync)
    );

    eid_combine #(.W(NPINS)) u_comb (
        .pins_i (pin_sync),
        .en_i   (pin_en_i),
        .line_o (line_w)
    );

    eid_detect u_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_i  (line_w),
        .sense_i (sense_i),
        .ack_i   (ack_i),
        .irq_o   (irq_w)
    );

    assign irq_o  = irq_w;
    assign wake_o = irq_w;
endmodule

// File: rtl/eid_checker.sv
module eid_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] sense_i,
    input logic       ack_i,
    input logic       line_i,
    input logic       irq_o
);
    logic prev_l;
    logic evt_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_l <= 1'b1;
        else         prev_l <= line_i;
    end

    always_comb begin
        case (sense_i)
            2'b01:   evt_c = line_i & ~prev_l;
            2'b10:   evt_c = ~line_i & prev_l;
            2'b11:   evt_c = line_i ^ prev_l;
            default: evt_c = 1'b0;
        endcase
    end

    a_r3_low_masks_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i == 2'b01 && $past(sense_i) == 2'b01 && !line_i && !irq_o)
        |=> (!irq_o || sense_i == 2'b00));

    a_r5_any_change_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i == 2'b11 && $past(sense_i) == 2'b11 && line_i != prev_l)
        |=> (irq_o || sense_i == 2'b00));

    a_r6_level_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i == 2'b00 && line_i) |-> !irq_o);

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i != 2'b00 && $past(sense_i) == sense_i && ack_i && !evt_c)
        |=> (!irq_o || sense_i == 2'b00));

    a_r7_held_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i != 2'b00 && $past(sense_i) == sense_i && irq_o && !ack_i)
        |=> (irq_o || sense_i == 2'b00));

    a_r8_mode_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i != $past(sense_i))
        |=> (!irq_o || sense_i == 2'b00));
endmodule

bind ext_irq_detect eid_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sense_i (sense_i),
    .ack_i   (ack_i),
    .line_i  (line_w),
    .irq_o   (irq_o)
);

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '1;
    logic [NP-1:0] en = '1;
    logic [1:0]    sense = 2'b00;
    logic          ack = 1'b0;
    logic          irq, wake;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_irq_detect #(.NPINS(NP), .SYNC_STAGES(2)) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pin_i    (pins),
        .pin_en_i (en),
        .sense_i  (sense),
        .ack_i    (ack),
        .irq_o    (irq),
        .wake_o   (wake)
    );

    function automatic logic line_of(logic [NP-1:0] p, logic [NP-1:0] e);
        return &(p | ~e);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b (sense=%b en=%b pins=%b)",
                     tag, act, exp, sense, en, pins);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 wake after reset", wake, 1'b0);

        // R9 latency, falling-edge mode
        sense = 2'b10; en = '1; pins = '1;
        tick(4); ack = 1'b1; tick(1); ack = 1'b0;
        pins = 3'b110;
        tick(2);
        chk("R9 edge not before third edge", irq, 1'b0);
        tick(1);
        chk("R9 edge after third edge", irq, 1'b1);
        // R7 held without ack
        tick(10);
        chk("R7 held without ack", irq, 1'b1);
        ack = 1'b1; tick(1); ack = 1'b0;
        chk("R7 cleared by ack", irq, 1'b0);

        // R8 sense change clears
        pins = '1; tick(4);
        pins = 3'b011; tick(4);
        chk("R8 pending before change", irq, 1'b1);
        sense = 2'b11; tick(1);
        chk("R8 cleared by sense change", irq, 1'b0);
        tick(4);
        chk("R8 no spurious event", irq, 1'b0);

        // R9 latency, level mode
        sense = 2'b00; pins = '1; tick(4);
        pins = 3'b101;
        tick(1);
        chk("R9 level not before second edge", irq, 1'b0);
        tick(1);
        chk("R9 level after second edge", irq, 1'b1);
        // R6 ack has no effect
        ack = 1'b1; tick(1); ack = 1'b0; tick(1);
        chk("R6 ack ignored in level mode", irq, 1'b1);
        pins = '1; tick(3);
        chk("R6 no latch after release", irq, 1'b0);

        // R3 low pin masks rise from others
        sense = 2'b01; en = '1; pins = 3'b110; tick(4);
        ack = 1'b1; tick(1); ack = 1'b0;
        pins = 3'b100; tick(4);
        pins = 3'b110; tick(4);
        chk("R3 held-low pin masks rise", irq, 1'b0);

        // R6 level sweep over masks and patterns (R2)
        sense = 2'b00;
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 8; p++) begin
                en = e[NP-1:0]; pins = p[NP-1:0];
                tick(3);
                chk("R2,R6 level sweep", irq, ~line_of(p[NP-1:0], e[NP-1:0]));
                chk("R10 wake follows", wake, irq);
            end
        end

        // Edge sweeps (R2, R3, R4, R5, R7, R10)
        for (int m = 1; m < 4; m++) begin
            for (int e = 0; e < 8; e++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int t = 0; t < 8; t++) begin
                        logic lf, lt, exp;
                        string tag;
                        sense = m[1:0]; en = e[NP-1:0]; pins = f[NP-1:0]; ack = 1'b0;
                        tick(4);
                        ack = 1'b1; tick(1); ack = 1'b0;
                        chk("R7 cleared before step", irq, 1'b0);
                        pins = t[NP-1:0];
                        tick(4);
                        lf = line_of(f[NP-1:0], e[NP-1:0]);
                        lt = line_of(t[NP-1:0], e[NP-1:0]);
                        case (m)
                            1:       begin exp = lt & ~lf; tag = "R2,R3 rising sweep";  end
                            2:       begin exp = ~lt & lf; tag = "R2,R4 falling sweep"; end
                            default: begin exp = lt ^ lf;  tag = "R2,R5 both sweep";    end
                        endcase
                        chk(tag, irq, exp);
                        chk("R10 wake follows", wake, irq);
                    end
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule